// File: doc/BRIEF.md
# Bitonic Eight-Key Merge Network

This block takes two runs of four keys each, both already in ascending order, and produces one ascending run of eight keys. The keys are 32-bit unsigned values. The second run is turned end for end before any comparison. The first run followed by the reversed second run is then a bitonic sequence: it rises and then falls.

A fixed cascade of compare-exchange levels sorts that sequence. Each level is a half-cleaner. At each level the lanes are first gathered into compare pairs, then each pair is replaced by its minimum and maximum, and the lanes are then scattered back to their places. The pair distance halves from one level to the next: four, then two, then one. The min of each pair lands on the lower lane.

Each level ends in a register. A new pair of runs can therefore be accepted on every clock, and each merged result appears a fixed number of cycles later. An input strobe marks the runs to merge, and an output strobe marks a finished result.

Top module: `bitonic_merge8`

## Requirements
- R1: Key k of `run_a`, `run_b` and `merged` occupies bits [32k+31:32k]. Lane 0 holds the smallest key of each run and of the result.
- R2: For two ascending input runs, `merged` holds the eight input keys in ascending order, and the result is a permutation of the inputs.
- R3: `out_valid` rises exactly three clock edges after an edge that samples `in_valid` high. The result it marks belongs to those inputs. An edge with `in_valid` low yields `out_valid` low three edges later.
- R4: Back-to-back strobes on consecutive cycles give back-to-back results, one per cycle, in input order.
- R5: Equal keys, within one run or across both runs, all appear in the output with their correct multiplicity.
- R6: After reset `out_valid` is 0 and all eight lanes of `merged` are 0.
- R7: Keys compare as unsigned values, so 32'hFFFF_FFFF sorts last and 0 sorts first.
- R8: While no result is being delivered, `merged` keeps the last delivered result (all zeros if there has been none). Idle cycles have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `run_a` and `run_b` as a pair to merge |
| run_a | input | 128 | First ascending run, four keys |
| run_b | input | 128 | Second ascending run, four keys |
| out_valid | output | 1 | Marks `merged` as a new result |
| merged | output | 256 | Ascending run of eight keys |

## Verification
Each merge result is due three rising edges after the edge that captured its inputs. The bench therefore drives the inputs on falling edges and checks the output on the falling edge three cycles after it drove each vector.

The stimulus runs as one stream per scenario. On each cycle the bench checks the result owed by the vector driven three cycles earlier, or, when no result is owed, checks that `out_valid` is low and that `merged` still holds the last result.

Expected values come from a two-pointer merge written in the bench. The scenarios cover disjoint runs, interleaved runs, duplicate keys, extreme keys, back-to-back streams and streams with gaps.

// File: rtl/bmn_pkg.sv
package bmn_pkg;

  localparam int unsigned KEY_BITS = 32;
  localparam int unsigned RUN_KEYS = 4;

  // Lower lane of compare pair p when partners sit STRIDE lanes apart.
  // Pairs are numbered densely; this is the gather half of the shuffle.
  function automatic int pair_low_lane(input int p, input int stride);
    return (p / stride) * 2 * stride + (p % stride);
  endfunction

  // Partner lane of the same pair.
  function automatic int pair_high_lane(input int p, input int stride);
    return pair_low_lane(p, stride) + stride;
  endfunction

endpackage

// File: rtl/bmn_form.sv
// Builds the bitonic sequence: run A unchanged in the low lanes, run B
// mirrored in the high lanes.
module bmn_form #(
  parameter int unsigned RUN   = bmn_pkg::RUN_KEYS,
  parameter int unsigned KEY_W = bmn_pkg::KEY_BITS,
  localparam int unsigned LANES = 2 * RUN
) (
  input  logic [RUN*KEY_W-1:0]          run_a,
  input  logic [RUN*KEY_W-1:0]          run_b,
  output logic [LANES-1:0][KEY_W-1:0]   seq
);

  for (genvar i = 0; i < RUN; i++) begin : g_lane
    assign seq[i]       = run_a[i*KEY_W +: KEY_W];
    assign seq[RUN + i] = run_b[(RUN-1-i)*KEY_W +: KEY_W];
  end

endmodule

// File: rtl/bmn_stage.sv
// One half-cleaner level: gather compare pairs, min/max each pair,
// scatter back, register.
module bmn_stage #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned KEY_W  = bmn_pkg::KEY_BITS,
  parameter int unsigned STRIDE = 4,
  localparam int unsigned PAIRS = LANES / 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [LANES-1:0][KEY_W-1:0]   in_keys,
  output logic                          out_valid,
  output logic [LANES-1:0][KEY_W-1:0]   out_keys
);
  import bmn_pkg::*;

  function automatic logic [KEY_W-1:0] key_min(input logic [KEY_W-1:0] x,
                                               input logic [KEY_W-1:0] y);
    return (y < x) ? y : x;
  endfunction

  function automatic logic [KEY_W-1:0] key_max(input logic [KEY_W-1:0] x,
                                               input logic [KEY_W-1:0] y);
    return (y < x) ? x : y;
  endfunction

  // Shuffled view: partners side by side.
  logic [PAIRS-1:0][KEY_W-1:0] pair_lo_in, pair_hi_in;
  logic [PAIRS-1:0][KEY_W-1:0] pair_lo_out, pair_hi_out;
  logic [LANES-1:0][KEY_W-1:0] exch_keys;
  logic                        load_en;

  assign load_en = in_valid;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int LO = pair_low_lane(p, STRIDE);
    localparam int HI = pair_high_lane(p, STRIDE);

    assign pair_lo_in[p]  = in_keys[LO];
    assign pair_hi_in[p]  = in_keys[HI];
    assign pair_lo_out[p] = key_min(pair_lo_in[p], pair_hi_in[p]);
    assign pair_hi_out[p] = key_max(pair_lo_in[p], pair_hi_in[p]);
    assign exch_keys[LO]  = pair_lo_out[p];
    assign exch_keys[HI]  = pair_hi_out[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_keys  <= '0;
    end else begin
      out_valid <= in_valid;
      if (load_en) out_keys <= exch_keys;
    end
  end

  AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R3

  AST_STAGE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R3

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_keys)); // R8

endmodule

// File: rtl/bitonic_merge8.sv
module bitonic_merge8 #(
  parameter int unsigned RUN   = bmn_pkg::RUN_KEYS,
  parameter int unsigned KEY_W = bmn_pkg::KEY_BITS,
  localparam int unsigned LANES  = 2 * RUN,
  localparam int unsigned LEVELS = $clog2(LANES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [RUN*KEY_W-1:0]     run_a,
  input  logic [RUN*KEY_W-1:0]     run_b,
  output logic                     out_valid,
  output logic [LANES*KEY_W-1:0]   merged
);

  logic [LANES-1:0][KEY_W-1:0] level_keys [0:LEVELS];
  logic                        level_vld  [0:LEVELS];

  bmn_form #(.RUN(RUN), .KEY_W(KEY_W)) u_form (
    .run_a (run_a),
    .run_b (run_b),
    .seq   (level_keys[0])
  );
  assign level_vld[0] = in_valid;

  // Pair distance halves at each level: LANES/2, ..., 1.
  for (genvar s = 0; s < LEVELS; s++) begin : g_level
    bmn_stage #(
      .LANES  (LANES),
      .KEY_W  (KEY_W),
      .STRIDE (LANES >> (s + 1))
    ) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (level_vld[s]),
      .in_keys   (level_keys[s]),
      .out_valid (level_vld[s+1]),
      .out_keys  (level_keys[s+1])
    );
  end

  assign out_valid = level_vld[LEVELS];
  assign merged    = level_keys[LEVELS];

  function automatic logic lanes_ascending(input logic [LANES*KEY_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 1; i < LANES; i++)
      if (v[i*KEY_W +: KEY_W] < v[(i-1)*KEY_W +: KEY_W]) ok = 1'b0;
    return ok;
  endfunction

  AST_OUT_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> lanes_ascending(merged)); // R2

  AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(merged)); // R1

endmodule

// File: tb/sim_bitonic_merge8.sv
`timescale 1ns/1ps
module sim_bitonic_merge8;

  localparam int LAT = 3;
  localparam int MAXV = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] run_a = '0;
  logic [127:0] run_b = '0;
  logic         out_valid;
  logic [255:0] merged;

  always #2.5 clk = ~clk;

  bitonic_merge8 u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .run_a(run_a), .run_b(run_b),
    .out_valid(out_valid), .merged(merged)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [31:0]  sa [0:MAXV-1][0:3];
  logic [31:0]  sb [0:MAXV-1][0:3];
  bit           sv [0:MAXV-1];
  logic [255:0] last_out = '0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Two-pointer reference merge.
  function automatic logic [255:0] ref_merge(input int v);
    logic [255:0] r;
    int ia, ib;
    ia = 0; ib = 0;
    for (int k = 0; k < 8; k++) begin
      if (ib >= 4 || (ia < 4 && sa[v][ia] <= sb[v][ib])) begin
        r[k*32 +: 32] = sa[v][ia]; ia++;
      end else begin
        r[k*32 +: 32] = sb[v][ib]; ib++;
      end
    end
    return r;
  endfunction

  task automatic sort4(inout logic [31:0] k [0:3]);
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 3 - i; j++)
        if (k[j+1] < k[j]) begin
          logic [31:0] t;
          t = k[j]; k[j] = k[j+1]; k[j+1] = t;
        end
  endtask

  task automatic fill_random(input int v, input logic [31:0] range);
    logic [31:0] ta [0:3];
    logic [31:0] tb [0:3];
    for (int i = 0; i < 4; i++) begin
      ta[i] = (range == 0) ? $urandom() : ($urandom() % range);
      tb[i] = (range == 0) ? $urandom() : ($urandom() % range);
    end
    sort4(ta); sort4(tb);
    for (int i = 0; i < 4; i++) begin
      sa[v][i] = ta[i]; sb[v][i] = tb[i];
    end
    sv[v] = 1'b1;
  endtask

  // Drive vectors at falling edges; vector t is checked LAT cycles later.
  task automatic run_stream(input int n, input string req);
    for (int t = 0; t < n + LAT; t++) begin
      int idx;
      @(negedge clk);
      idx = t - LAT;
      if (idx >= 0 && sv[idx]) begin
        logic [255:0] e;
        e = ref_merge(idx);
        check(out_valid === 1'b1, {req, " R3 strobe"}, {255'd0, out_valid}, 256'd1);
        check(merged === e, req, merged, e);
        last_out = e;
      end else begin
        check(out_valid === 1'b0, {req, " R3 no strobe"}, {255'd0, out_valid}, 256'd0);
        check(merged === last_out, {req, " R8 hold"}, merged, last_out);
      end
      if (t < n) begin
        in_valid = sv[t];
        for (int i = 0; i < 4; i++) begin
          run_a[i*32 +: 32] = sa[t][i];
          run_b[i*32 +: 32] = sb[t][i];
        end
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic set_vec(input int v, input logic [31:0] a0, a1, a2, a3,
                         input logic [31:0] b0, b1, b2, b3);
    sa[v][0] = a0; sa[v][1] = a1; sa[v][2] = a2; sa[v][3] = a3;
    sb[v][0] = b0; sb[v][1] = b1; sb[v][2] = b2; sb[v][3] = b3;
    sv[v] = 1'b1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(out_valid === 1'b0, "R6 out_valid", {255'd0, out_valid}, 256'd0);
    check(merged === 256'd0, "R6 merged", merged, 256'd0);
  endtask

  task automatic t_basic;
    set_vec(0, 1, 4, 6, 9, 2, 3, 7, 8);
    run_stream(1, "R1 R2 interleaved");
  endtask

  task automatic t_disjoint;
    set_vec(0, 10, 11, 12, 13, 20, 21, 22, 23);
    set_vec(1, 50, 60, 70, 80, 1, 2, 3, 4);
    run_stream(2, "R2 disjoint");
  endtask

  task automatic t_duplicates;
    set_vec(0, 5, 5, 5, 5, 5, 5, 5, 5);
    set_vec(1, 3, 3, 7, 7, 3, 7, 7, 9);
    set_vec(2, 0, 2, 2, 4, 2, 2, 2, 2);
    run_stream(3, "R5 duplicates");
  endtask

  task automatic t_extremes;
    set_vec(0, 0, 1, 32'h8000_0000, 32'hFFFF_FFFF,
               0, 32'h7FFF_FFFF, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
    set_vec(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
               0, 0, 0, 0);
    run_stream(2, "R7 unsigned extremes");
  endtask

  task automatic t_back_to_back;
    for (int v = 0; v < 20; v++) fill_random(v, (v % 2) ? 32'd16 : 32'd0);
    run_stream(20, "R4 back-to-back");
  endtask

  task automatic t_gaps;
    for (int v = 0; v < 16; v++) begin
      fill_random(v, 32'd100);
      sv[v] = (v % 3) != 1;
    end
    run_stream(16, "R8 gaps");
  endtask

  initial begin
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_basic();
    t_disjoint();
    t_duplicates();
    t_extremes();
    t_back_to_back();
    t_gaps();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule